// File: doc/BRIEF.md
# Closed-Loop Trace Message Injector

This block plays a stored list of messages into an on-chip network model. Software or a test harness first writes the list through a load port. Each entry gets a message ID equal to its position in the list. A start pulse then begins the replay. An entry is one of two kinds. An independent entry waits for a global cycle count to reach its timestamp. A dependent entry waits for the delivery of another message, plus a programmed number of cycles. Because the network reports each delivery back to the block, the replay is closed-loop: congestion that delays one message also delays every message that depends on it.

Entries are fetched in list order into a small window of pending slots. Every slot is re-examined every cycle. The eligible entry with the lowest ID is handed to a one-deep output register, which presents descriptors on a valid/ready stream.

Back-pressure rules:
- Once `msg_valid` is high, the descriptor stays unchanged until a cycle in which `msg_ready` is high.
- A new descriptor may follow in the very next cycle after a transfer.
- While the output is stalled, eligible entries keep waiting in the window.
- When the window is full, fetching stops.

Top module: `trace_injector`

## Requirements
- R1: A write with `ld_we` high stores the entry at `ld_addr`, and that address becomes the entry's message ID. A `start` pulse latches `rec_count` and replays entries 0 to `rec_count`-1. It also clears all delivery records. Every emitted descriptor carries the source, destination and length that were stored for its ID.
- R2: An independent entry (`ld_dep`=0, `ld_time` = absolute timestamp) becomes eligible in the first cycle in which it sits in the window and `cycle_now` >= timestamp. With the output free, `msg_valid` for it is seen in the following cycle, never earlier.
- R3: A cycle with `dlv_valid` high records the value of `cycle_now` as the receipt time of message `dlv_id` and marks that message as delivered.
- R4: A dependent entry (`ld_dep`=1, `ld_trig` = trigger ID, `ld_time` = delay) becomes eligible in cycle t when its trigger's delivered mark is set and t >= receipt time + delay. The mark is visible from the cycle after the notification. Its descriptor appears one cycle after it becomes eligible.
- R5: A dependent entry whose trigger has not been delivered is never emitted, and `done` stays low while it waits.
- R6: When several entries are eligible, the lowest message ID is emitted first, which is trace order.
- R7: While `msg_valid` is high and `msg_ready` is low, `msg_valid` stays high and the ID, source, destination and length stay unchanged in the next cycle.
- R8: The window holds `PEND_DEPTH` (8) entries. While it is full, no further entry is fetched, so a later entry cannot be emitted before a slot frees, even if its own time has passed.
- R9: `done` is high once every entry has been fetched and emitted, the window is empty and the output is idle. It is low from the start pulse until then.
- R10: After reset, `msg_valid` and `done` are low.
- R11: Every entry of the replayed trace is emitted exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_we | input | 1 | Trace entry write strobe |
| ld_addr | input | 4 | Entry position, also its message ID |
| ld_dep | input | 1 | 1 = dependent entry, 0 = independent |
| ld_time | input | 16 | Timestamp (independent) or delay (dependent) |
| ld_trig | input | 4 | Trigger message ID for a dependent entry |
| ld_src | input | 4 | Source node |
| ld_dst | input | 4 | Destination node |
| ld_len | input | 4 | Message length |
| rec_count | input | 5 | Number of entries to replay, latched at start |
| start | input | 1 | Pulse that begins a replay |
| cycle_now | input | 16 | Global cycle count |
| dlv_valid | input | 1 | Delivery notification strobe |
| dlv_id | input | 4 | ID of the delivered message |
| msg_valid | output | 1 | Descriptor valid |
| msg_ready | input | 1 | Consumer accepts descriptor |
| msg_src | output | 4 | Descriptor source |
| msg_dst | output | 4 | Descriptor destination |
| msg_len | output | 4 | Descriptor length |
| msg_id | output | 4 | Descriptor message ID |
| done | output | 1 | Replay complete |

## Verification
The hardest state to reach from the ports is a window full of dependent entries whose trigger is late, with a ready independent entry queued behind them. The bench builds this state with eight dependents that all wait a long time on message 0, followed by an early-stamped independent entry. It then checks that the independent entry comes out only after all eight dependents.

The withheld-trigger case is reached by having the bench's network model suppress one delivery notification for a while and then release it. The bench also sweeps the dependency delay and the number of entries that share a timestamp. For each message it computes the exact cycle of first appearance from the recorded delivery times.

// File: rtl/inj_pkg.sv
package inj_pkg;
  localparam int IDX_W   = 4;
  localparam int NUM_MSG = 1 << IDX_W;
  localparam int TS_W    = 16;
  localparam int NODE_W  = 4;
  localparam int LEN_W   = 4;

  typedef struct packed {
    logic              dep;
    logic [TS_W-1:0]   tval;
    logic [IDX_W-1:0]  trig;
    logic [NODE_W-1:0] src;
    logic [NODE_W-1:0] dst;
    logic [LEN_W-1:0]  len;
    logic [IDX_W-1:0]  id;
  } rec_t;
endpackage

// File: rtl/inj_receipt.sv
module inj_receipt
  import inj_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clr,
  input  logic                            dlv_valid,
  input  logic [IDX_W-1:0]                dlv_id,
  input  logic [TS_W-1:0]                 now,
  output logic [NUM_MSG-1:0]              got,
  output logic [NUM_MSG-1:0][TS_W-1:0]    at
);
  // delivered marks: cleared at every replay start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         got <= '0;
    else if (clr)       got <= '0;
    else if (dlv_valid) got[dlv_id] <= 1'b1;
  end

  // receipt times, only meaningful where the mark is set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 at <= '0;
    else if (dlv_valid && !clr) at[dlv_id] <= now;
  end
endmodule

// File: rtl/inj_pend_table.sv
module inj_pend_table
  import inj_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         ins_valid,
  input  rec_t                         ins_rec,
  input  logic                         take,
  input  logic [TS_W-1:0]              now,
  input  logic [NUM_MSG-1:0]           got,
  input  logic [NUM_MSG-1:0][TS_W-1:0] at,
  output logic                         full,
  output logic                         empty,
  output logic                         sel_valid,
  output rec_t                         sel_rec
);
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  rec_t              ent [DEPTH];
  logic [DEPTH-1:0]  vld;
  logic [DEPTH-1:0]  elig;
  logic [SLOT_W-1:0] sel_slot;
  logic [SLOT_W-1:0] ins_slot;
  logic [IDX_W-1:0]  best_id;
  logic              free_found;

  // per-slot eligibility, evaluated every cycle
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [TS_W:0] due_t;
    logic          trig_ok;
    assign due_t   = ent[g].dep ? ({1'b0, at[ent[g].trig]} + {1'b0, ent[g].tval})
                                : {1'b0, ent[g].tval};
    assign trig_ok = ent[g].dep ? got[ent[g].trig] : 1'b1;
    assign elig[g] = vld[g] && trig_ok && ({1'b0, now} >= due_t);
  end

  // lowest message ID among eligible slots wins
  always_comb begin
    sel_valid = 1'b0;
    sel_slot  = '0;
    best_id   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (elig[i] && (!sel_valid || ent[i].id < best_id)) begin
        sel_valid = 1'b1;
        sel_slot  = SLOT_W'(i);
        best_id   = ent[i].id;
      end
    end
  end

  assign sel_rec = ent[sel_slot];

  // first free slot receives the next fetched entry
  always_comb begin
    ins_slot   = '0;
    free_found = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld[i] && !free_found) begin
        ins_slot   = SLOT_W'(i);
        free_found = 1'b1;
      end
    end
  end

  assign full  = &vld;
  assign empty = ~|vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else if (clr) vld <= '0;
    else begin
      if (take)      vld[sel_slot] <= 1'b0;
      if (ins_valid) vld[ins_slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_valid && !clr) ent[ins_slot] <= ins_rec;
  end
endmodule

// File: rtl/inj_out_slot.sv
module inj_out_slot
  import inj_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  rec_t din,
  input  logic ready,
  output logic can_load,
  output logic valid,
  output rec_t q
);
  assign can_load = !valid || ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     valid <= 1'b0;
    else if (load)  valid <= 1'b1;
    else if (ready) valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) q <= din;
  end
endmodule

// File: rtl/trace_injector.sv
module trace_injector
  import inj_pkg::*;
#(
  parameter int PEND_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_we,
  input  logic [IDX_W-1:0]  ld_addr,
  input  logic              ld_dep,
  input  logic [TS_W-1:0]   ld_time,
  input  logic [IDX_W-1:0]  ld_trig,
  input  logic [NODE_W-1:0] ld_src,
  input  logic [NODE_W-1:0] ld_dst,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic [IDX_W:0]    rec_count,
  input  logic              start,
  input  logic [TS_W-1:0]   cycle_now,
  input  logic              dlv_valid,
  input  logic [IDX_W-1:0]  dlv_id,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [NODE_W-1:0] msg_src,
  output logic [NODE_W-1:0] msg_dst,
  output logic [LEN_W-1:0]  msg_len,
  output logic [IDX_W-1:0]  msg_id,
  output logic              done
);
  rec_t mem [NUM_MSG];

  logic                         running;
  logic [IDX_W:0]               rp;
  logic [IDX_W:0]               count_q;
  logic                         ins_valid;
  rec_t                         ins_rec;
  logic                         tbl_full, tbl_empty;
  logic                         sel_valid;
  rec_t                         sel_rec;
  logic                         take;
  logic                         can_load;
  rec_t                         out_q;
  logic [NUM_MSG-1:0]           rcv_got;
  logic [NUM_MSG-1:0][TS_W-1:0] rcv_at;

  // trace store
  always_ff @(posedge clk) begin
    if (ld_we) begin
      mem[ld_addr].dep  <= ld_dep;
      mem[ld_addr].tval <= ld_time;
      mem[ld_addr].trig <= ld_trig;
      mem[ld_addr].src  <= ld_src;
      mem[ld_addr].dst  <= ld_dst;
      mem[ld_addr].len  <= ld_len;
      mem[ld_addr].id   <= ld_addr;
    end
  end

  // read pointer walks the trace in order, stalls on a full window
  assign ins_valid = running && !start && (rp < count_q) && !tbl_full;
  assign ins_rec   = mem[rp[IDX_W-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      rp      <= '0;
      count_q <= '0;
    end else if (start) begin
      running <= 1'b1;
      rp      <= '0;
      count_q <= rec_count;
    end else if (ins_valid) begin
      rp <= rp + 1'b1;
    end
  end

  inj_receipt u_rcv (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (start),
    .dlv_valid (dlv_valid),
    .dlv_id    (dlv_id),
    .now       (cycle_now),
    .got       (rcv_got),
    .at        (rcv_at)
  );

  inj_pend_table #(.DEPTH(PEND_DEPTH)) u_tbl (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (start),
    .ins_valid (ins_valid),
    .ins_rec   (ins_rec),
    .take      (take),
    .now       (cycle_now),
    .got       (rcv_got),
    .at        (rcv_at),
    .full      (tbl_full),
    .empty     (tbl_empty),
    .sel_valid (sel_valid),
    .sel_rec   (sel_rec)
  );

  assign take = sel_valid && can_load;

  inj_out_slot u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (take),
    .din      (sel_rec),
    .ready    (msg_ready),
    .can_load (can_load),
    .valid    (msg_valid),
    .q        (out_q)
  );

  assign msg_src = out_q.src;
  assign msg_dst = out_q.dst;
  assign msg_len = out_q.len;
  assign msg_id  = out_q.id;
  assign done    = running && (rp == count_q) && tbl_empty && !msg_valid;
endmodule

// File: rtl/inj_checker.sv
module inj_checker
  import inj_pkg::*;
(
  input logic                         clk,
  input logic                         rst_n,
  input logic                         start,
  input logic                         dlv_valid,
  input logic [IDX_W-1:0]             dlv_id,
  input logic [TS_W-1:0]              cycle_now,
  input logic [NUM_MSG-1:0]           got,
  input logic [NUM_MSG-1:0][TS_W-1:0] at,
  input logic                         full,
  input logic                         running,
  input logic [IDX_W:0]               rp,
  input logic [IDX_W:0]               count_q,
  input logic                         msg_valid,
  input logic                         msg_ready,
  input logic [IDX_W-1:0]             msg_id,
  input logic [NODE_W-1:0]            msg_src,
  input logic [NODE_W-1:0]            msg_dst,
  input logic [LEN_W-1:0]             msg_len,
  input logic                         done
);
  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable({msg_id, msg_src, msg_dst, msg_len})); // R7

  AST_DELIVERY_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && !start |=> got[$past(dlv_id)] && (at[$past(dlv_id)] == $past(cycle_now))); // R3

  AST_FULL_WINDOW_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    running && full && !start |=> $stable(rp)); // R8

  AST_DONE_IDLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !msg_valid && (rp == count_q)); // R9

  AST_ID_IN_TRACE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> ({1'b0, msg_id} < count_q)); // R1

  AST_NO_DONE_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !done && !msg_valid); // R10
endmodule

bind trace_injector inj_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .dlv_valid (dlv_valid),
  .dlv_id    (dlv_id),
  .cycle_now (cycle_now),
  .got       (rcv_got),
  .at        (rcv_at),
  .full      (tbl_full),
  .running   (running),
  .rp        (rp),
  .count_q   (count_q),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .msg_id    (msg_id),
  .msg_src   (msg_src),
  .msg_dst   (msg_dst),
  .msg_len   (msg_len),
  .done      (done)
);

// File: tb/sim_trace_injector.sv
module sim_trace_injector;
  import inj_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ld_we = 1'b0;
  logic [IDX_W-1:0]  ld_addr = '0;
  logic              ld_dep = 1'b0;
  logic [TS_W-1:0]   ld_time = '0;
  logic [IDX_W-1:0]  ld_trig = '0;
  logic [NODE_W-1:0] ld_src = '0;
  logic [NODE_W-1:0] ld_dst = '0;
  logic [LEN_W-1:0]  ld_len = '0;
  logic [IDX_W:0]    rec_count = '0;
  logic              start = 1'b0;
  logic [TS_W-1:0]   cnt;
  logic              dlv_valid = 1'b0;
  logic [IDX_W-1:0]  dlv_id = '0;
  logic              msg_valid;
  logic              msg_ready = 1'b1;
  logic [NODE_W-1:0] msg_src;
  logic [NODE_W-1:0] msg_dst;
  logic [LEN_W-1:0]  msg_len;
  logic [IDX_W-1:0]  msg_id;
  logic              done;

  always #2 clk = ~clk;

  trace_injector u0 (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_dep(ld_dep),
    .ld_time(ld_time), .ld_trig(ld_trig), .ld_src(ld_src), .ld_dst(ld_dst),
    .ld_len(ld_len), .rec_count(rec_count), .start(start), .cycle_now(cnt),
    .dlv_valid(dlv_valid), .dlv_id(dlv_id), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_src(msg_src), .msg_dst(msg_dst),
    .msg_len(msg_len), .msg_id(msg_id), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench copy of the trace
  int t_dep [16], t_tv [16], t_trig [16], t_src [16], t_dst [16], t_len [16];
  // per-run observations
  int fv [16], emit [16], due [16], c_at [16];
  bit fv_seen [16], hs_seen [16], dlvd [16], sup [16];
  int ord [64];
  int nord;
  bit exact, rdy_mode, mon_on;
  logic [15:0] lfsr = 16'hACE1;
  bit prev_stall;
  int p_id, p_src, p_dst, p_len;
  localparam int NET_LAT = 3;

  // network model, ready driver and output monitor
  always @(negedge clk) begin
    if (mon_on) begin
      dlv_valid = 1'b0;
      for (int i = 0; i < 16; i++) begin
        if (!dlv_valid && hs_seen[i] && !dlvd[i] && !sup[i] && due[i] <= int'(cnt)) begin
          dlv_valid = 1'b1;
          dlv_id    = IDX_W'(i);
          dlvd[i]   = 1'b1;
          c_at[i]   = int'(cnt);
        end
      end
      msg_ready = rdy_mode ? lfsr[0] : 1'b1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (prev_stall)
        chk(msg_valid && int'(msg_id) == p_id && int'(msg_src) == p_src &&
            int'(msg_dst) == p_dst && int'(msg_len) == p_len,
            "R7 descriptor held under stall", int'(msg_id), p_id);
      if (msg_valid) begin
        automatic int id = int'(msg_id);
        if (!fv_seen[id]) begin
          automatic int e;
          fv_seen[id] = 1'b1;
          fv[id] = int'(cnt);
          if (t_dep[id] != 0) begin
            chk(dlvd[t_trig[id]], "R5 trigger delivered before release", 0, 1);
            e = c_at[t_trig[id]] + t_tv[id];
            if (e < c_at[t_trig[id]] + 1) e = c_at[t_trig[id]] + 1;
          end else begin
            e = t_tv[id];
          end
          chk(int'(cnt) >= e + 1, t_dep[id] != 0 ? "R4 not early" : "R2 not early", int'(cnt), e + 1);
          if (exact)
            chk(int'(cnt) == e + 1, t_dep[id] != 0 ? "R4 exact cycle" : "R2 exact cycle", int'(cnt), e + 1);
          chk(int'(msg_src) == t_src[id] && int'(msg_dst) == t_dst[id] && int'(msg_len) == t_len[id],
              "R1 descriptor fields", {msg_src, msg_dst, msg_len}, (t_src[id] << 8) | (t_dst[id] << 4) | t_len[id]);
        end
        if (msg_ready) begin
          emit[id]++;
          if (nord < 64) ord[nord] = id;
          nord++;
          hs_seen[id] = 1'b1;
          due[id] = int'(cnt) + NET_LAT;
        end
      end
      prev_stall = msg_valid && !msg_ready;
      p_id = int'(msg_id); p_src = int'(msg_src); p_dst = int'(msg_dst); p_len = int'(msg_len);
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic put(int a, int dep, int tv, int trig);
    @(negedge clk);
    t_dep[a] = dep; t_tv[a] = tv; t_trig[a] = trig;
    t_src[a] = (a * 5 + 1) % 16; t_dst[a] = (a * 3 + 7) % 16; t_len[a] = (a + 2) % 16;
    ld_we = 1'b1; ld_addr = IDX_W'(a); ld_dep = dep[0]; ld_time = TS_W'(tv);
    ld_trig = IDX_W'(trig); ld_src = NODE_W'(t_src[a]); ld_dst = NODE_W'(t_dst[a]);
    ld_len = LEN_W'(t_len[a]);
  endtask

  task automatic end_load();
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic kick(int n, bit ex, bit rm);
    for (int i = 0; i < 16; i++) begin
      fv[i] = 0; emit[i] = 0; due[i] = 0; c_at[i] = 0;
      fv_seen[i] = 0; hs_seen[i] = 0; dlvd[i] = 0;
    end
    nord = 0; prev_stall = 0; exact = ex; rdy_mode = rm; mon_on = 1'b1;
    @(negedge clk);
    start = 1'b1; rec_count = (IDX_W+1)'(n);
    @(negedge clk);
    start = 1'b0;
    chk(!done, "R9 low after start", done, 0);
  endtask

  task automatic finish_run(int n, string tag);
    for (int k = 0; k < 3000 && !done; k++) @(negedge clk);
    chk(done, "R9 done raised", done, 1);
    for (int i = 0; i < 16; i++)
      chk(emit[i] == ((i < n) ? 1 : 0), "R11 emitted once", emit[i], (i < n) ? 1 : 0);
  endtask

  task automatic chk_order(int n, string req);
    chk(nord == n, req, nord, n);
    for (int i = 0; i < n && i < 64; i++) chk(ord[i] == i, req, ord[i], i);
  endtask

  initial begin
    int b;
    mon_on = 1'b0;
    for (int i = 0; i < 16; i++) sup[i] = 0;
    repeat (3) @(negedge clk);
    chk(msg_valid == 1'b0, "R10 msg_valid after reset", msg_valid, 0);
    chk(done == 1'b0, "R10 done after reset", done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(msg_valid == 1'b0 && done == 1'b0, "R10 idle before start", {msg_valid, done}, 0);

    // S1: mixed chain, exact cycle of each release
    b = int'(cnt) + 40;
    put(0, 0, b, 0); put(1, 0, b + 10, 0); put(2, 1, 5, 0);
    put(3, 1, 0, 1); put(4, 1, 2, 3); put(5, 0, b + 30, 0);
    end_load();
    kick(6, 1'b1, 1'b0);
    finish_run(6, "S1");

    // S2: shared timestamp groups of sizes 2..6, trace order (R6)
    for (int n = 2; n <= 6; n++) begin
      b = int'(cnt) + 30;
      for (int i = 0; i < n; i++) put(i, 0, b, 0);
      end_load();
      kick(n, 1'b0, 1'b0);
      finish_run(n, "S2");
      chk_order(n, "R6 trace order on tie");
      chk(fv[0] == b + 1, "R2 first of group on time", fv[0], b + 1);
    end

    // S3: dependency delay sweep, exact timing (R4)
    for (int d = 0; d <= 6; d++) begin
      b = int'(cnt) + 30;
      put(0, 0, b, 0); put(1, 1, d, 0); put(2, 1, d, 1);
      end_load();
      kick(3, 1'b1, 1'b0);
      finish_run(3, "S3");
    end

    // S4: back-pressure with a mixed trace (R7, R11)
    b = int'(cnt) + 30;
    for (int i = 0; i < 12; i++) begin
      if (i % 2 == 0) put(i, 0, b + 3 * i, 0);
      else            put(i, 1, i % 4, i - 1);
    end
    end_load();
    kick(12, 1'b0, 1'b1);
    finish_run(12, "S4");

    // S5: full window blocks a later early entry (R8)
    b = int'(cnt) + 30;
    put(0, 0, b, 0);
    for (int i = 1; i <= 8; i++) put(i, 1, 60, 0);
    put(9, 0, b + 5, 0);
    end_load();
    kick(10, 1'b0, 1'b0);
    finish_run(10, "S5");
    chk_order(10, "R8 order behind full window");
    chk(fv[9] > fv[8], "R8 later entry after blocked ones", fv[9], fv[8] + 1);
    chk(fv[9] > b + 56, "R8 fetch held while full", fv[9], b + 57);

    // S6: withheld trigger keeps a dependent pending (R5, R9)
    b = int'(cnt) + 30;
    put(0, 0, b, 0); put(1, 1, 2, 0);
    end_load();
    sup[0] = 1;
    kick(2, 1'b1, 1'b0);
    repeat (150) @(negedge clk);
    chk(emit[0] == 1, "R2 independent released", emit[0], 1);
    chk(emit[1] == 0, "R5 dependent held without delivery", emit[1], 0);
    chk(!done, "R5 done low while waiting", done, 0);
    sup[0] = 0;
    finish_run(2, "S6");

    mon_on = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule